// File: doc/BRIEF.md
# Flash Address Range Protection Filter

This block sits between a requester and a serial flash command engine and decides, in the same cycle, whether a flash operation may proceed. Each request presents an 8-bit opcode and a 24-bit flash address. The filter compares the address against a small set of protected windows. It also compares the opcode against a packed list of restricted opcodes. It raises `req_block` when a restricted operation would touch a protected window.

Software sets up the filter through a narrow write-only register port. There are four window entries, one restricted-opcode word and a status bit. The restricted-opcode word can be written only once. A window entry can be written only while it is still zero. After boot, the protection set can therefore only grow until the next reset. Every blocked request sets a sticky violation flag, and software clears that flag explicitly.

Top module: `flash_range_guard`

## Requirements
- R1: After reset `req_block` and `violation` are low, and no request is blocked until both a window entry and the restricted-opcode word have been written.
- R2: A window entry is written with `cfg_sel` = 0..3. Its layout is: index in bits 7:0, size bit 8, write-guard bit 9, read-guard bit 10, base in bits 23:16. All other bits are ignored. With bit 8 clear, the window covers addresses base×65536 + index×4096 through that value + 4095.
- R3: With bit 8 set, the window covers base×65536 + index×65536 through that value + 65535.
- R4: An address below base×65536 never falls inside that entry's window.
- R5: The restricted-opcode word is written with `cfg_sel` = 4. Its bits 31:24, 23:16 and 15:8 hold the write-class opcodes. A valid request whose opcode equals one of these is blocked when its address lies in a window whose write-guard bit is set.
- R6: Bits 7:0 of the restricted-opcode word hold the read opcode. A valid request with that opcode is blocked when its address lies in a window whose read-guard bit is set. A write guard does not block the read opcode, and a read guard does not block the write-class opcodes.
- R7: An opcode field that holds 0x00 never matches, and a request with opcode 0x00 is never blocked.
- R8: Only the first write to the restricted-opcode word takes effect. Later writes are ignored.
- R9: A window entry whose stored fields are all zero is unused and never matches. A write to an entry takes effect only while that entry is still zero.
- R10: A cycle in which `req_valid` is high and the request is blocked sets `violation` at the next clock edge. `violation` stays set until a write with `cfg_sel` = 5 and `cfg_wdata[0]` = 1. If a block and such a clear fall in the same cycle, the block wins. With `req_valid` low nothing is blocked.
- R11: `req_block` is a combinational result of the current request and of the configuration registered before the current clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0..3 window entry, 4 restricted-opcode word, 5 status |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | A request is present this cycle |
| req_opcode | input | 8 | Opcode of the request |
| req_addr | input | 24 | Flash byte address of the request |
| req_block | output | 1 | Request must not be issued |
| violation | output | 1 | Sticky flag set by a blocked request |

## Verification
The bench builds the filter with its default parameters: four entries, a 24-bit address, an 8-bit index, and 4 KiB and 64 KiB units. With these values the bench can place a window at a nonzero base and probe just below that base. It can place a 64 KiB window at index 255, whose last byte is the final flash address. It can test both edges of each unit size. A behavioural model computes window bounds arithmetically. The bench compares it with `req_block` in the cycle of the request and with `violation` after the clock edge. These comparisons cover the write-once and grow-only configuration rules as well as the set-over-clear priority.

// File: rtl/flash_range_guard.sv
module flash_range_guard #(
  parameter int NUM_RANGES = 4,
  parameter int ADDR_W     = 24,
  parameter int IDX_W      = 8,
  parameter int SM_SH      = 12,
  parameter int LG_SH      = 16,
  parameter int SEL_W      = $clog2(NUM_RANGES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [7:0]        req_opcode,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_block,
  output logic              violation
);
  localparam int OP_W    = 8;
  localparam int BASE_W  = ADDR_W - LG_SH;
  localparam int ENT_W   = BASE_W + IDX_W + 3;
  localparam int EXT_W   = ADDR_W + 1;
  localparam int CMD_SEL = NUM_RANGES;
  localparam int STS_SEL = NUM_RANGES + 1;

  logic [NUM_RANGES-1:0][ENT_W-1:0] rng_q;
  logic [4*OP_W-1:0]                cmd_q;
  logic                             cmd_lock;
  logic [NUM_RANGES-1:0]            wp_hit, rp_hit;
  logic [ENT_W-1:0]                 ent_wr;

  assign ent_wr = {cfg_wdata[16 +: BASE_W], cfg_wdata[IDX_W+2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rng_q    <= '0;
      cmd_q    <= '0;
      cmd_lock <= 1'b0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_RANGES; i++)
        if (cfg_sel == SEL_W'(i) && rng_q[i] == '0)
          rng_q[i] <= ent_wr;
      if (cfg_sel == SEL_W'(CMD_SEL) && !cmd_lock) begin
        cmd_q    <= cfg_wdata;
        cmd_lock <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
    logic [IDX_W-1:0]  idx;
    logic              unit_lg, wp, rp;
    logic [BASE_W-1:0] base;
    logic [EXT_W-1:0]  lo, hi, a;
    logic              hit;

    assign idx     = rng_q[g][IDX_W-1:0];
    assign unit_lg = rng_q[g][IDX_W];
    assign wp      = rng_q[g][IDX_W+1];
    assign rp      = rng_q[g][IDX_W+2];
    assign base    = rng_q[g][ENT_W-1 -: BASE_W];
    assign a       = {1'b0, req_addr};
    assign lo      = (EXT_W'(base) << LG_SH)
                   + (unit_lg ? (EXT_W'(idx) << LG_SH) : (EXT_W'(idx) << SM_SH));
    assign hi      = lo + (unit_lg ? (EXT_W'(1) << LG_SH) : (EXT_W'(1) << SM_SH));
    assign hit     = (a >= lo) && (a < hi);
    assign wp_hit[g] = hit && wp;
    assign rp_hit[g] = hit && rp;
  end

  logic op_nz, w_op, r_op;
  assign op_nz = req_opcode != '0;
  assign w_op  = op_nz && (req_opcode == cmd_q[31:24] ||
                           req_opcode == cmd_q[23:16] ||
                           req_opcode == cmd_q[15:8]);
  assign r_op  = op_nz && (req_opcode == cmd_q[7:0]);

  assign req_block = req_valid && (((|wp_hit) && w_op) || ((|rp_hit) && r_op));

  always_ff @(posedge clk) begin
    if (!rst_n)
      violation <= 1'b0;
    else if (req_block)
      violation <= 1'b1;
    else if (cfg_we && cfg_sel == SEL_W'(STS_SEL) && cfg_wdata[0])
      violation <= 1'b0;
  end
endmodule

// File: rtl/flash_range_guard_chk.sv
module flash_range_guard_chk #(
  parameter int NUM_RANGES = 4,
  parameter int ENT_W      = 19,
  parameter int SEL_W      = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             cfg_we,
  input logic [SEL_W-1:0]                 cfg_sel,
  input logic [31:0]                      cfg_wdata,
  input logic                             req_valid,
  input logic [7:0]                       req_opcode,
  input logic                             req_block,
  input logic                             violation,
  input logic                             cmd_lock,
  input logic [31:0]                      cmd_q,
  input logic [NUM_RANGES-1:0][ENT_W-1:0] rng_q
);
  localparam int STS_SEL = NUM_RANGES + 1;

  p_lock_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lock |=> $stable(cmd_q));

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_once
    p_entry_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rng_q[g] != '0) |=> $stable(rng_q[g]));
  end

  p_zero_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_opcode == 8'h00) |-> !req_block);

  p_no_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == '0) |-> !req_block);

  p_valid_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_block);

  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_block |=> violation);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && !(cfg_we && cfg_sel == SEL_W'(STS_SEL) && cfg_wdata[0])) |=> violation);
endmodule

bind flash_range_guard flash_range_guard_chk #(
  .NUM_RANGES(NUM_RANGES), .ENT_W(ENT_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_opcode(req_opcode),
  .req_block(req_block), .violation(violation), .cmd_lock(cmd_lock),
  .cmd_q(cmd_q), .rng_q(rng_q)
);

// File: tb/tb_flash_range_guard.sv
`timescale 1ns/1ps
module tb_flash_range_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [7:0]  req_opcode;
  logic [23:0] req_addr;
  logic        req_block;
  logic        violation;

  int checks = 0;
  int errors = 0;

  int unsigned m_rng [4];
  int unsigned m_cmd;
  bit          m_lock;
  bit          m_viol;

  always #2 clk = ~clk;

  flash_range_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .req_block(req_block), .violation(violation)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic bit model_block(input bit v, input int unsigned op, input int unsigned a);
    bit wg = 0, rg = 0;
    for (int i = 0; i < 4; i++) begin
      int unsigned e, lo, sz;
      e = m_rng[i];
      if (e == 0) continue;
      sz = e[8] ? 65536 : 4096;
      lo = ((e >> 16) & 255) * 65536 + (e & 255) * sz;
      if (a >= lo && a < lo + sz) begin
        wg |= e[9];
        rg |= e[10];
      end
    end
    if (!v || op == 0) return 0;
    if (wg && (op == ((m_cmd >> 24) & 255) || op == ((m_cmd >> 16) & 255) ||
               op == ((m_cmd >> 8) & 255))) return 1;
    if (rg && op == (m_cmd & 255)) return 1;
    return 0;
  endfunction

  task automatic cyc(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                     input logic v, input logic [7:0] op, input logic [23:0] a,
                     input string tag);
    bit eb;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    req_valid = v; req_opcode = op; req_addr = a;
    #1;
    eb = model_block(v, op, a);
    check(req_block, eb, {tag, " block"});
    @(posedge clk);
    if (we) begin
      if (sel < 4 && m_rng[sel] == 0) m_rng[sel] = wd & 32'h00FF07FF;
      if (sel == 4 && !m_lock) begin m_cmd = wd; m_lock = 1; end
      if (sel == 5 && wd[0]) m_viol = 0;
    end
    if (eb) m_viol = 1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check(violation, m_viol, {tag, " violation"});
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] wd, input string tag);
    cyc(1'b1, sel, wd, 1'b0, 8'h00, 24'h0, tag);
  endtask

  task automatic rq(input logic [7:0] op, input logic [23:0] a, input string tag);
    cyc(1'b0, 3'd0, 32'h0, 1'b1, op, a, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_rng = '{default: 0}; m_cmd = 0; m_lock = 0; m_viol = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_opcode = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(req_block, 1'b0, "R1 reset block");
    check(violation, 1'b0, "R1 reset violation");
    @(negedge clk);

    rq(8'h02, 24'h003000, "R1 unconfigured");
    wr(3'd0, 32'h0000_0203, "R2 write entry0");
    rq(8'h00, 24'h003000, "R7 zero opcode, empty word");
    rq(8'h02, 24'h003000, "R7 word unwritten");
    wr(3'd4, 32'h0602_D803, "R8 first word write");

    rq(8'h02, 24'h003000, "R2 low edge");
    rq(8'h02, 24'h003FFF, "R11 R2 high edge");
    rq(8'h02, 24'h002FFF, "R2 below window, R10 sticky");
    rq(8'h02, 24'h004000, "R2 above window");
    rq(8'h06, 24'h003800, "R5 write enable");
    rq(8'hD8, 24'h003800, "R5 erase");
    rq(8'h03, 24'h003800, "R6 read under write guard");
    rq(8'h05, 24'h003800, "R5 unlisted opcode");
    rq(8'h00, 24'h003800, "R7 zero opcode");

    wr(3'd5, 32'h0000_0001, "R10 clear");
    rq(8'h02, 24'h003000, "R10 set again");
    wr(3'd5, 32'h0000_0000, "R10 clear bit low");
    cyc(1'b1, 3'd5, 32'h1, 1'b1, 8'h02, 24'h003000, "R10 set beats clear");
    wr(3'd5, 32'h0000_0001, "R10 clear again");
    cyc(1'b0, 3'd0, 32'h0, 1'b0, 8'h02, 24'h003000, "R10 valid low");

    wr(3'd1, 32'h0010_0502, "R3 write entry1");
    rq(8'h03, 24'h120000, "R3 low edge");
    rq(8'h03, 24'h12FFFF, "R3 high edge");
    rq(8'h03, 24'h11FFFF, "R3 below window");
    rq(8'h03, 24'h130000, "R3 above window");
    rq(8'h02, 24'h120000, "R6 program under read guard");
    wr(3'd5, 32'h0000_0001, "R10 clear after R3");

    wr(3'd2, 32'h0080_0200, "R4 write entry2");
    rq(8'h02, 24'h800000, "R4 at base");
    rq(8'h02, 24'h7FF000, "R4 below base");
    rq(8'h02, 24'h000000, "R4 address zero");

    wr(3'd4, 32'hFFFF_FFFF, "R8 second word write");
    rq(8'hFF, 24'h003000, "R8 new opcode ignored");
    rq(8'h02, 24'h003000, "R8 first word kept");

    wr(3'd0, 32'h0000_0205, "R9 rewrite entry0");
    rq(8'h02, 24'h005000, "R9 rewrite ignored");
    rq(8'h02, 24'h003000, "R9 old entry kept");
    rq(8'h02, 24'hFFF000, "R9 unused entry3");
    wr(3'd3, 32'h0000_03FF, "R3 write entry3 top");
    rq(8'hD8, 24'hFFFFFF, "R3 last address");
    rq(8'hD8, 24'hFEFFFF, "R3 below top window");
    wr(3'd5, 32'h0000_0001, "R10 final clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule